// File: doc/BRIEF.md
# I2C Master SCL Waveform Generator

This block times the two halves of the SCL clock for an I2C master, counting system clock cycles. The low half lasts `low_div * 2^prescale + 4` cycles and the high half lasts `high_div * 2^prescale + 4` cycles. `low_div` and `high_div` are 8-bit dividers and `prescale` is a 3-bit power-of-two exponent. Firmware works out these three values from the wanted bus speed. The block itself only counts.

A bit-level engine uses `scl_pull` to drive the open-drain SCL line low. It uses the one-cycle `phase_end` strobe, together with `in_low`, to know when to change SDA or sample it. When the block releases SCL, a slow target can hold the line low. While `scl_sense` still reads low, the high-half count pauses, so the target can stretch the clock. The block copies the configuration only when a low half starts. A configuration written in the middle of a period therefore never shortens the half that is running.

All pins are plain control and status signals. No data stream passes through the block, so there is no handshake and no back-pressure.

Top module: `scl_wavegen`

## Requirements
- R1: While `enable` is low, on the cycle after it is sampled low, `scl_pull`, `in_low` and `phase_end` are all 0 and the count restarts from zero.
- R2: On the first clock edge where `enable` is sampled high, a low half begins. The low half lasts `low_div * 2^prescale + 4` cycles, and `scl_pull` and `in_low` are 1 for exactly those cycles.
- R3: Each low half is followed by a high half with `scl_pull` at 0. With `scl_sense` high, the high half lasts `high_div * 2^prescale + 4` cycles. After it, the next low half starts.
- R4: `phase_end` is 1 for exactly one cycle per half: the last cycle of that half. In that cycle `in_low` shows which half is ending (1 for the low half).
- R5: In a high half, any cycle in which `scl_sense` is sampled low does not count. Holding `scl_sense` low for N cycles therefore lengthens the high half by exactly N cycles.
- R6: The divider and prescale inputs are copied when each low half starts. Changes made during a period take effect at the next low half.
- R7: If `enable` falls in the middle of a half, SCL is released on the next cycle. When `enable` returns, timing restarts with a full low half.
- R8: With `high_div` equal to `low_div`, the two halves have equal length (50% duty).
- R9: The extreme settings are counted correctly: divider 0 gives a 4-cycle half, and divider 255 with prescale 7 gives a 32644-cycle half.
- R10: During a low half, the count ignores `scl_sense`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator; when low, SCL is released and the count is cleared |
| low_div | input | 8 | Low-half divider |
| high_div | input | 8 | High-half divider |
| prescale | input | 3 | Power-of-two exponent applied to both dividers |
| scl_sense | input | 1 | Level read back from the SCL line |
| scl_pull | output | 1 | 1 = drive SCL low, 0 = release SCL |
| in_low | output | 1 | 1 while the low half is running |
| phase_end | output | 1 | One-cycle strobe on the last cycle of each half |

## Verification
The bench sweeps prescale 0 to 3 against a set of divider values, with unequal high and low dividers. This shows whether the exponent really shifts the divider, and whether each half uses its own divider rather than its partner's. A pass with equal dividers checks symmetric duty. The two extreme corners check the full count width and the 4-cycle floor. Further runs cover the following:
- a high half stretched by a held-low `scl_sense`, which tells a frozen count apart from a running one;
- `scl_sense` forced low during a low half, which must not change its length;
- a configuration change in mid-period, which must show up only one period later;
- a mid-half disable, which must release SCL at once.

// File: rtl/scl_wavegen_pkg.sv
package scl_wavegen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/scl_cfg_shadow.sv
// Holds the divider set used by the current SCL period; reloaded only on load.
module scl_cfg_shadow #(
  parameter int DIV_W = 8,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] lo_in,
  input  logic [DIV_W-1:0] hi_in,
  input  logic [PRE_W-1:0] pre_in,
  output logic [DIV_W-1:0] lo_q,
  output logic [DIV_W-1:0] hi_q,
  output logic [PRE_W-1:0] pre_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      pre_q <= '0;
    end else if (load) begin
      lo_q  <= lo_in;
      hi_q  <= hi_in;
      pre_q <= pre_in;
    end
  end
endmodule

// File: rtl/scl_phase_len.sv
// Phase length in system cycles: (div << pre) + OFFSET.
module scl_phase_len #(
  parameter int DIV_W  = 8,
  parameter int PRE_W  = 3,
  parameter int OFFSET = 4,
  parameter int LEN_W  = 16
) (
  input  logic [DIV_W-1:0] div,
  input  logic [PRE_W-1:0] pre,
  output logic [LEN_W-1:0] len
);
  always_comb begin
    len = (LEN_W'(div) << pre) + LEN_W'(OFFSET);
  end
endmodule

// File: rtl/scl_phase_counter.sv
// Counts advancing cycles of a phase; last marks the final advancing cycle.
module scl_phase_counter #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [LEN_W-1:0] len,
  output logic             last,
  output logic [LEN_W-1:0] count
);
  always_comb begin
    last = advance && (count == len - LEN_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (advance) begin
      count <= last ? '0 : count + LEN_W'(1);
    end
  end
endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen
  import scl_wavegen_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int PRE_W  = 3,
  parameter int OFFSET = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] low_div,
  input  logic [DIV_W-1:0] high_div,
  input  logic [PRE_W-1:0] prescale,
  input  logic             scl_sense,
  output logic             scl_pull,
  output logic             in_low,
  output logic             phase_end
);
  localparam int MAX_SHIFT = (1 << PRE_W) - 1;
  localparam int LEN_W     = DIV_W + MAX_SHIFT + 1;

  scl_phase_e       state;
  logic [DIV_W-1:0] lo_q, hi_q, sel_div;
  logic [PRE_W-1:0] pre_q;
  logic [LEN_W-1:0] cur_len, count;
  logic             load, clear, advance, last;

  always_comb begin
    load    = enable && ((state == PH_IDLE) || (state == PH_HIGH && last));
    clear   = !enable || (state == PH_IDLE);
    advance = (state == PH_LOW) || (state == PH_HIGH && scl_sense);
    sel_div = (state == PH_HIGH) ? hi_q : lo_q;
  end

  scl_cfg_shadow #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load),
    .lo_in(low_div), .hi_in(high_div), .pre_in(prescale),
    .lo_q(lo_q), .hi_q(hi_q), .pre_q(pre_q)
  );

  scl_phase_len #(.DIV_W(DIV_W), .PRE_W(PRE_W), .OFFSET(OFFSET), .LEN_W(LEN_W)) u_len (
    .div(sel_div), .pre(pre_q), .len(cur_len)
  );

  scl_phase_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(clear), .advance(advance),
    .len(cur_len), .last(last), .count(count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PH_IDLE;
    end else if (!enable) begin
      state <= PH_IDLE;
    end else begin
      unique case (state)
        PH_IDLE: state <= PH_LOW;
        PH_LOW:  if (last) state <= PH_HIGH;
        PH_HIGH: if (last) state <= PH_LOW;
        default: state <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_pull  = (state == PH_LOW);
    in_low    = (state == PH_LOW);
    phase_end = enable && last;
  end

  // Independent run-length tracker for the low half, used by the checks below.
  logic [LEN_W-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (enable && state == PH_LOW && !phase_end) low_run <= low_run + LEN_W'(1);
    else low_run <= '0;
  end

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_pull && !phase_end)); // R1
  AST_LOW_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_end && state == PH_LOW) |->
      (low_run + LEN_W'(1) == (LEN_W'(lo_q) << pre_q) + LEN_W'(OFFSET))); // R2
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_end |=> !phase_end); // R4
  AST_LOW_TO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_end && in_low) |=> (!scl_pull && state == PH_HIGH)); // R3
  AST_STRETCH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == PH_HIGH && !scl_sense) |=> $stable(count)); // R5
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state != PH_IDLE && !(state == PH_HIGH && phase_end)) |=>
      ($stable(lo_q) && $stable(hi_q) && $stable(pre_q))); // R6
endmodule

// File: tb/scl_wavegen_tb.sv
`timescale 1ns/1ps
module scl_wavegen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] low_div = '0, high_div = '0;
  logic [2:0] prescale = '0;
  logic       hold = 1'b0;
  logic       force_low = 1'b0;
  logic       scl_sense, scl_pull, in_low, phase_end;
  int         n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;
  assign scl_sense = ~scl_pull & ~hold & ~force_low;

  scl_wavegen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .low_div(low_div), .high_div(high_div), .prescale(prescale),
    .scl_sense(scl_sense), .scl_pull(scl_pull), .in_low(in_low), .phase_end(phase_end)
  );

  function automatic int exp_len(int d, int p);
    return d * (1 << p) + 4;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Measures one full period starting at the next low half. stretch = held-low cycles in high half.
  task automatic period(input int stretch, output int lo, output int hi,
                        output int lo_done, output int hi_done);
    int lo_flag_bad = 0;
    lo = 0; hi = 0; lo_done = -1; hi_done = -1;
    while (!scl_pull) @(negedge clk);
    while (scl_pull) begin
      lo++;
      if (in_low !== 1'b1) lo_flag_bad = 1;
      if (phase_end) begin
        if (lo_done != -1) lo_done = -2;
        else lo_done = lo;
      end
      @(negedge clk);
    end
    chk("R4 in_low during low half", lo_flag_bad, 0);
    while (!scl_pull) begin
      hi++;
      hold = (hi <= stretch);
      if (phase_end) begin
        if (hi_done != -1) hi_done = -2;
        else hi_done = hi;
      end
      @(negedge clk);
    end
    hold = 1'b0;
  endtask

  task automatic restart(input int lo, input int hi, input int pre);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R1 released while disabled", int'(scl_pull), 0);
    chk("R1 no strobe while disabled", int'(phase_end), 0);
    low_div = 8'(lo); high_div = 8'(hi); prescale = 3'(pre);
    enable = 1'b1;
  endtask

  initial begin
    int lo, hi, ld, hd;
    int divs[6] = '{0, 1, 2, 7, 13, 40};
    repeat (3) @(negedge clk);
    chk("R1 reset scl_pull", int'(scl_pull), 0);
    chk("R1 reset in_low", int'(in_low), 0);
    chk("R1 reset phase_end", int'(phase_end), 0);
    rst_n = 1'b1;

    // R2/R3/R4 sweep with unequal dividers
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 6; i++) begin
        int dl = divs[i];
        int dh = (dl * 3 + 5) % 64;
        restart(dl, dh, p);
        period(0, lo, hi, ld, hd);
        chk("R2 low length", lo, exp_len(dl, p));
        chk("R3 high length", hi, exp_len(dh, p));
        chk("R4 low strobe position", ld, lo);
        chk("R4 high strobe position", hd, hi);
        period(0, lo, hi, ld, hd);
        chk("R3 steady second period low", lo, exp_len(dl, p));
      end
    end

    // R8 equal dividers
    for (int p = 0; p < 4; p++) begin
      restart(9 + p, 9 + p, p);
      period(0, lo, hi, ld, hd);
      chk("R8 equal halves", hi, lo);
      chk("R8 half length", lo, exp_len(9 + p, p));
    end

    // R5 stretching
    for (int s = 1; s <= 7; s += 3) begin
      restart(3, 5, 1);
      period(s, lo, hi, ld, hd);
      chk("R5 stretched high length", hi, exp_len(5, 1) + s);
      chk("R5 strobe at stretched end", hd, hi);
      chk("R5 low unaffected", lo, exp_len(3, 1));
    end

    // R10 scl_sense low during low half has no effect
    restart(6, 2, 2);
    while (!scl_pull) @(negedge clk);
    force_low = 1'b1;
    lo = 0;
    while (scl_pull) begin lo++; @(negedge clk); end
    force_low = 1'b0;
    chk("R10 low length with sense low", lo, exp_len(6, 2));

    // R6 configuration change mid-period
    restart(4, 6, 1);
    while (!scl_pull) @(negedge clk);
    low_div = 8'd20; high_div = 8'd11; prescale = 3'd2;
    period(0, lo, hi, ld, hd);
    chk("R6 current low keeps old cfg", lo, exp_len(4, 1));
    chk("R6 current high keeps old cfg", hi, exp_len(6, 1));
    period(0, lo, hi, ld, hd);
    chk("R6 next low uses new cfg", lo, exp_len(20, 2));
    chk("R6 next high uses new cfg", hi, exp_len(11, 2));

    // R7 mid-half disable then restart
    restart(30, 3, 0);
    while (!scl_pull) @(negedge clk);
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R7 released after disable", int'(scl_pull), 0);
    chk("R7 no strobe after disable", int'(phase_end), 0);
    enable = 1'b1;
    period(0, lo, hi, ld, hd);
    chk("R7 full low after re-enable", lo, exp_len(30, 0));

    // R9 extremes
    restart(255, 0, 7);
    period(0, lo, hi, ld, hd);
    chk("R9 max low", lo, 32644);
    chk("R9 min high", hi, 4);
    restart(0, 255, 7);
    period(0, lo, hi, ld, hd);
    chk("R9 min low", lo, 4);
    chk("R9 max high", hi, 32644);
    chk("R9 max high strobe", hd, 32644);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule